// File: doc/BRIEF.md
# Ramp-Compare Accessory Identifier

This block works out which accessory hangs on a connector's identification line. An external comparator checks the line voltage against a reference, and the block drives that reference with a 5-bit code. The code starts at zero when an accessory appears and climbs one step at a time. Each step is held for `SETTLE_CYC` clocks so the comparator can settle. The first code at which the comparator reports high is latched as the identification code. If the comparator never goes high, the latched code ends at 31.

The latched code is decoded into an accessory class. In automatic mode, the class also selects which analog switches close: the high-speed data pair, the UART pair, the factory JIG line and the BOOT line. Switches close only after a programmable wait has run out. In manual mode, two 3-bit selectors, one per data line, choose the switches. A master enable forces every switch open. When raw mode is on, the block keeps rescanning the line while the accessory stays attached, and it reports when the code changes. Attach and detach are reported as one-cycle pulses. A detach opens every switch at once.

The controller is a state machine with five states:
- IDLE: no accessory. It leaves IDLE for RAMP on an attach.
- RAMP: the first scan. It goes to WAIT on a latch.
- WAIT: the switching delay. It goes to LINK when the timer expires.
- LINK: the code is in force. It goes to RESCAN when raw mode is set.
- RESCAN: a repeat scan. It returns to LINK on a latch.

A detach sends every state back to IDLE.

Top module: `acc_id_ramp`

## Requirements
- R1: After reset, the outputs are `ref_code_o`=0, `id_code_o`=31, `code_valid_o`=0 and `dev_class_o`=0, with every switch output, `reserved_o`, `chg_det_o` and every pulse output low.
- R2: On an attach, `ref_code_o` starts at 0. Each code is held for `SETTLE_CYC` clocks, and `cmp_i` is sampled in the last clock of the step. The first code that samples high is latched into `id_code_o`, and `code_valid_o` rises `SETTLE_CYC*(code+1)` clocks after the attach pulse.
- R3: If `cmp_i` never samples high, the latched code saturates at 31, which is the no-resistor class.
- R4: In automatic mode, switches follow the class. OTG (code 0), the chargers (23, 27) and the factory USB cables (24, 25) close both high-speed lines. The phone-powered device (20), the UART cable (22) and the factory UART cables (28, 29) close both UART lines. The factory cables (24, 25, 28, 29) close JIG. Codes 25 and 29 also close BOOT. Every other code keeps all switches open.
- R5: `reserved_o` is high while a reserved accessory (codes 15 to 18) is in force, and those codes close no switch. `chg_det_o` is high while code 31 is in force and `vbus_i` is high. This output hands the attach on to charger-type detection.
- R6: Switches close `W+1` clocks after `code_valid_o` rises, where `W = WAIT_UNIT_CYC*(1+2*s)` and s is `wait_sel_i`. Any setting above `WAIT_SEL_MAX` is treated as `WAIT_SEL_MAX`.
- R7: With `auto_sw_i`=0, each line's 3-bit selector chooses the switch. Value 001 picks the high-speed line and 011 picks the UART line. Any other value (000, 010 or one of the invalid codes) leaves that line open. JIG and BOOT stay open in this mode.
- R8: With `sw_enable_i`=0, every switch output is 0 one clock later, whatever the mode.
- R9: `attach_o` and `detach_o` are one-clock pulses, one clock after the level change on `acc_present_i`. The `detach_o` pulse coincides with all switches open, `code_valid_o`=0 and `id_code_o`=31.
- R10: With raw mode off, after a latch no new scan runs until the next attach. `ref_code_o` and `id_code_o` hold even if the comparator changes.
- R11: With raw mode on, a new scan starts each time LINK is reached. `adc_chg_o` pulses for one clock when a rescan latches a code that differs from the held one, and `id_code_o` takes the new code. An unchanged code gives no pulse.
- R12: `dev_class_o` gives the class of the code in force, and is 0 outside LINK and RESCAN. The class values are: 1 OTG (0); 2 unlisted codes; 3 audio type 3 (14); 4 reserved (15 to 18); 5 audio type 2 (19); 6 phone-powered device (20); 7 TTY (21); 8 UART cable (22); 9 charger (23, 27); 10 factory USB (24); 11 factory USB with boot (25); 12 audio/video (26); 13 factory UART (28); 14 factory UART with boot (29); 15 headset (30); 16 no ID (31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_present_i | input | 1 | Level: an accessory is present on the connector |
| vbus_i | input | 1 | Level: bus supply present |
| cmp_i | input | 1 | Comparator result, high when the reference is at or above the line voltage |
| raw_mode_i | input | 1 | 1 = rescan continuously while attached |
| auto_sw_i | input | 1 | 1 = automatic switching, 0 = manual selectors |
| sw_enable_i | input | 1 | 0 = force all switches open |
| man_dp_sel_i | input | 3 | Manual selector for the data-plus line |
| man_dm_sel_i | input | 3 | Manual selector for the data-minus line |
| wait_sel_i | input | 4 | Switching-wait setting |
| ref_code_o | output | 5 | Reference code driven to the comparator |
| id_code_o | output | 5 | Latched identification code |
| code_valid_o | output | 1 | A code has been latched since the attach |
| dev_class_o | output | 5 | Accessory class of the code in force |
| reserved_o | output | 1 | Reserved accessory in force |
| chg_det_o | output | 1 | Hand-off to charger-type detection |
| sw_dp_hs_o | output | 1 | Data-plus to high-speed line |
| sw_dm_hs_o | output | 1 | Data-minus to high-speed line |
| sw_dp_uart_o | output | 1 | Data-plus to UART receive line |
| sw_dm_uart_o | output | 1 | Data-minus to UART transmit line |
| sw_jig_o | output | 1 | Factory JIG line driven |
| sw_boot_o | output | 1 | Factory BOOT line driven |
| attach_o | output | 1 | Attach pulse |
| detach_o | output | 1 | Detach pulse |
| adc_chg_o | output | 1 | Rescan found a different code |

## Verification
The assertions take the following for granted about the inputs:
- `acc_present_i` is a clean, synchronous level that never toggles on two successive clocks.
- `cmp_i` is monotonic in `ref_code_o`: once a step samples high, every higher code would also sample high.

The bench respects both conditions. It derives the comparator from a threshold held in the bench, compared against the live reference code. It moves the threshold and the configuration only at falling edges. It keeps every presence level for many clocks, so a ramp and its wait always finish before the next change.

// File: rtl/acc_id_pkg.sv
package acc_id_pkg;

    localparam int ID_W = 5;
    localparam logic [ID_W-1:0] ID_MAX = '1;
    localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

    // manual selector values for one data line
    localparam logic [2:0] MSEL_HS   = 3'b001;
    localparam logic [2:0] MSEL_UART = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RAMP   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_LINK   = 3'd3,
        ST_RESCAN = 3'd4
    } acc_state_e;

    typedef enum logic [4:0] {
        CL_NONE          = 5'd0,
        CL_OTG           = 5'd1,
        CL_UNKNOWN       = 5'd2,
        CL_AUDIO3        = 5'd3,
        CL_RESERVED      = 5'd4,
        CL_AUDIO2        = 5'd5,
        CL_PPD           = 5'd6,
        CL_TTY           = 5'd7,
        CL_UART          = 5'd8,
        CL_CHARGER       = 5'd9,
        CL_FAC_USB       = 5'd10,
        CL_FAC_USB_BOOT  = 5'd11,
        CL_AV            = 5'd12,
        CL_FAC_UART      = 5'd13,
        CL_FAC_UART_BOOT = 5'd14,
        CL_HEADSET       = 5'd15,
        CL_NO_ID         = 5'd16
    } acc_class_e;

    typedef struct packed {
        logic dp_hs;
        logic dm_hs;
        logic dp_uart;
        logic dm_uart;
        logic jig;
        logic boot;
    } sw_set_t;

endpackage

// File: rtl/acc_id_decode.sv
module acc_id_decode
    import acc_id_pkg::*;
(
    input  logic [ID_W-1:0] code_i,
    output acc_class_e      class_o,
    output sw_set_t         sw_o
);

    always_comb begin
        unique case (code_i)
            5'b00000:                             class_o = CL_OTG;
            5'b01110:                             class_o = CL_AUDIO3;
            5'b01111, 5'b10000, 5'b10001, 5'b10010: class_o = CL_RESERVED;
            5'b10011:                             class_o = CL_AUDIO2;
            5'b10100:                             class_o = CL_PPD;
            5'b10101:                             class_o = CL_TTY;
            5'b10110:                             class_o = CL_UART;
            5'b10111, 5'b11011:                   class_o = CL_CHARGER;
            5'b11000:                             class_o = CL_FAC_USB;
            5'b11001:                             class_o = CL_FAC_USB_BOOT;
            5'b11010:                             class_o = CL_AV;
            5'b11100:                             class_o = CL_FAC_UART;
            5'b11101:                             class_o = CL_FAC_UART_BOOT;
            5'b11110:                             class_o = CL_HEADSET;
            5'b11111:                             class_o = CL_NO_ID;
            default:                              class_o = CL_UNKNOWN;
        endcase
    end

    always_comb begin
        sw_o = '0;
        unique case (class_o)
            CL_OTG, CL_CHARGER, CL_FAC_USB: begin
                sw_o.dp_hs = 1'b1;
                sw_o.dm_hs = 1'b1;
                sw_o.jig   = (class_o == CL_FAC_USB);
            end
            CL_FAC_USB_BOOT: begin
                sw_o.dp_hs = 1'b1;
                sw_o.dm_hs = 1'b1;
                sw_o.jig   = 1'b1;
                sw_o.boot  = 1'b1;
            end
            CL_PPD, CL_UART, CL_FAC_UART: begin
                sw_o.dp_uart = 1'b1;
                sw_o.dm_uart = 1'b1;
                sw_o.jig     = (class_o == CL_FAC_UART);
            end
            CL_FAC_UART_BOOT: begin
                sw_o.dp_uart = 1'b1;
                sw_o.dm_uart = 1'b1;
                sw_o.jig     = 1'b1;
                sw_o.boot    = 1'b1;
            end
            default: sw_o = '0;
        endcase
    end

endmodule

// File: rtl/acc_id_switch_sel.sv
module acc_id_switch_sel
    import acc_id_pkg::*;
(
    input  logic    sw_enable_i,
    input  logic    auto_sw_i,
    input  logic [2:0] man_dp_sel_i,
    input  logic [2:0] man_dm_sel_i,
    input  sw_set_t auto_set_i,
    output sw_set_t sw_o
);

    always_comb begin
        sw_o = '0;
        if (!sw_enable_i) begin
            sw_o = '0;
        end else if (auto_sw_i) begin
            sw_o = auto_set_i;
        end else begin
            sw_o.dp_hs   = (man_dp_sel_i == MSEL_HS);
            sw_o.dp_uart = (man_dp_sel_i == MSEL_UART);
            sw_o.dm_hs   = (man_dm_sel_i == MSEL_HS);
            sw_o.dm_uart = (man_dm_sel_i == MSEL_UART);
        end
    end

endmodule

// File: rtl/acc_id_wait_timer.sv
module acc_id_wait_timer #(
    parameter int UNIT_CYC = 4,
    parameter int SEL_MAX  = 10,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);

    localparam int LONGEST = UNIT_CYC * (1 + 2 * SEL_MAX);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    int               sel_eff;

    always_comb begin
        sel_eff = 32'(sel_i);
        if (sel_eff > SEL_MAX) begin
            sel_eff = SEL_MAX;
        end
        limit = CNT_W'(UNIT_CYC * (1 + 2 * sel_eff) - 1);
    end

    assign done_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/acc_id_ctl.sv
module acc_id_ctl
    import acc_id_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            present_i,
    input  logic            vbus_i,
    input  logic            cmp_i,
    input  logic            raw_mode_i,
    input  logic            wait_done_i,
    input  acc_class_e      class_i,
    input  sw_set_t         sw_i,
    output logic            waiting_o,
    output logic [ID_W-1:0] ref_code_o,
    output logic [ID_W-1:0] id_code_o,
    output logic            code_valid_o,
    output acc_class_e      class_o,
    output sw_set_t         sw_o,
    output logic            reserved_o,
    output logic            chg_det_o,
    output logic            attach_o,
    output logic            detach_o,
    output logic            adc_chg_o
);

    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    acc_state_e      state_q, state_d;
    logic            pres_q;
    logic [SET_W-1:0] settle_q;
    logic [ID_W-1:0] ref_q;
    logic [ID_W-1:0] id_q;
    logic            valid_q;

    logic attach_evt, detach_evt, step_end, hit, scanning, linked;

    assign attach_evt = present_i && !pres_q;
    assign detach_evt = !present_i && pres_q;
    assign scanning   = (state_q == ST_RAMP) || (state_q == ST_RESCAN);
    assign linked     = (state_q == ST_LINK) || (state_q == ST_RESCAN);
    assign step_end   = scanning && (settle_q == SET_LAST);
    assign hit        = step_end && (cmp_i || (ref_q == ID_MAX));
    assign waiting_o  = (state_q == ST_WAIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (detach_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (attach_evt)  state_d = ST_RAMP;
                ST_RAMP:   if (hit)         state_d = ST_WAIT;
                ST_WAIT:   if (wait_done_i) state_d = ST_LINK;
                ST_LINK:   if (raw_mode_i)  state_d = ST_RESCAN;
                ST_RESCAN: if (hit)         state_d = ST_LINK;
                default:                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ramp datapath and latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q   <= 1'b0;
            settle_q <= '0;
            ref_q    <= '0;
            id_q     <= ID_MAX;
            valid_q  <= 1'b0;
        end else begin
            pres_q <= present_i;
            if (detach_evt) begin
                settle_q <= '0;
                ref_q    <= '0;
                id_q     <= ID_MAX;
                valid_q  <= 1'b0;
            end else if (scanning) begin
                if (step_end) begin
                    settle_q <= '0;
                    if (hit) begin
                        id_q    <= ref_q;
                        valid_q <= 1'b1;
                    end else begin
                        ref_q <= ref_q + ID_ONE;
                    end
                end else begin
                    settle_q <= settle_q + SET_W'(1);
                end
            end else if ((state_q == ST_IDLE && attach_evt) ||
                         (state_q == ST_LINK && raw_mode_i)) begin
                settle_q <= '0;
                ref_q    <= '0;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_o    <= CL_NONE;
            sw_o       <= '0;
            reserved_o <= 1'b0;
            chg_det_o  <= 1'b0;
            attach_o   <= 1'b0;
            detach_o   <= 1'b0;
            adc_chg_o  <= 1'b0;
        end else begin
            attach_o  <= attach_evt;
            detach_o  <= detach_evt;
            adc_chg_o <= !detach_evt && (state_q == ST_RESCAN) && hit && (ref_q != id_q);
            if (detach_evt || !linked) begin
                class_o    <= CL_NONE;
                sw_o       <= '0;
                reserved_o <= 1'b0;
                chg_det_o  <= 1'b0;
            end else begin
                class_o    <= class_i;
                sw_o       <= sw_i;
                reserved_o <= (class_i == CL_RESERVED);
                chg_det_o  <= (class_i == CL_NO_ID) && vbus_i;
            end
        end
    end

    assign ref_code_o   = ref_q;
    assign id_code_o    = id_q;
    assign code_valid_o = valid_q;

endmodule

// File: rtl/acc_id_ramp.sv
module acc_id_ramp
    import acc_id_pkg::*;
#(
    parameter int SETTLE_CYC    = 3,
    parameter int WAIT_UNIT_CYC = 4,
    parameter int WAIT_SEL_MAX  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_present_i,
    input  logic       vbus_i,
    input  logic       cmp_i,
    input  logic       raw_mode_i,
    input  logic       auto_sw_i,
    input  logic       sw_enable_i,
    input  logic [2:0] man_dp_sel_i,
    input  logic [2:0] man_dm_sel_i,
    input  logic [3:0] wait_sel_i,
    output logic [4:0] ref_code_o,
    output logic [4:0] id_code_o,
    output logic       code_valid_o,
    output logic [4:0] dev_class_o,
    output logic       reserved_o,
    output logic       chg_det_o,
    output logic       sw_dp_hs_o,
    output logic       sw_dm_hs_o,
    output logic       sw_dp_uart_o,
    output logic       sw_dm_uart_o,
    output logic       sw_jig_o,
    output logic       sw_boot_o,
    output logic       attach_o,
    output logic       detach_o,
    output logic       adc_chg_o
);

    logic       waiting, wait_done;
    acc_class_e dec_class, class_q;
    sw_set_t    auto_set, sel_set, sw_q;

    acc_id_ctl #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .present_i    (acc_present_i),
        .vbus_i       (vbus_i),
        .cmp_i        (cmp_i),
        .raw_mode_i   (raw_mode_i),
        .wait_done_i  (wait_done),
        .class_i      (dec_class),
        .sw_i         (sel_set),
        .waiting_o    (waiting),
        .ref_code_o   (ref_code_o),
        .id_code_o    (id_code_o),
        .code_valid_o (code_valid_o),
        .class_o      (class_q),
        .sw_o         (sw_q),
        .reserved_o   (reserved_o),
        .chg_det_o    (chg_det_o),
        .attach_o     (attach_o),
        .detach_o     (detach_o),
        .adc_chg_o    (adc_chg_o)
    );

    acc_id_wait_timer #(
        .UNIT_CYC (WAIT_UNIT_CYC),
        .SEL_MAX  (WAIT_SEL_MAX),
        .SEL_W    (4)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (waiting),
        .sel_i  (wait_sel_i),
        .done_o (wait_done)
    );

    acc_id_decode u_decode (
        .code_i  (id_code_o),
        .class_o (dec_class),
        .sw_o    (auto_set)
    );

    acc_id_switch_sel u_sel (
        .sw_enable_i  (sw_enable_i),
        .auto_sw_i    (auto_sw_i),
        .man_dp_sel_i (man_dp_sel_i),
        .man_dm_sel_i (man_dm_sel_i),
        .auto_set_i   (auto_set),
        .sw_o         (sel_set)
    );

    assign dev_class_o  = class_q;
    assign sw_dp_hs_o   = sw_q.dp_hs;
    assign sw_dm_hs_o   = sw_q.dm_hs;
    assign sw_dp_uart_o = sw_q.dp_uart;
    assign sw_dm_uart_o = sw_q.dm_uart;
    assign sw_jig_o     = sw_q.jig;
    assign sw_boot_o    = sw_q.boot;

endmodule

// File: rtl/acc_id_ramp_chk.sv
module acc_id_ramp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_enable_i,
    input logic [4:0] ref_code_o,
    input logic [4:0] id_code_o,
    input logic       code_valid_o,
    input logic       reserved_o,
    input logic       sw_dp_hs_o,
    input logic       sw_dm_hs_o,
    input logic       sw_dp_uart_o,
    input logic       sw_dm_uart_o,
    input logic       sw_jig_o,
    input logic       sw_boot_o,
    input logic       attach_o,
    input logic       detach_o,
    input logic       adc_chg_o
);

    logic any_sw;
    assign any_sw = sw_dp_hs_o | sw_dm_hs_o | sw_dp_uart_o | sw_dm_uart_o | sw_jig_o | sw_boot_o;

    a_r9_attach_single: assert property (@(posedge clk) disable iff (!rst_n)
        attach_o |=> !attach_o);

    a_r9_detach_single: assert property (@(posedge clk) disable iff (!rst_n)
        detach_o |=> !detach_o);

    a_r9_detach_opens: assert property (@(posedge clk) disable iff (!rst_n)
        detach_o |-> (!any_sw && !code_valid_o && id_code_o == 5'd31));

    a_r8_force_open: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_enable_i) |-> !any_sw);

    a_r7_line_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_dp_hs_o && sw_dp_uart_o) && !(sw_dm_hs_o && sw_dm_uart_o));

    a_r4_boot_needs_jig: assert property (@(posedge clk) disable iff (!rst_n)
        sw_boot_o |-> sw_jig_o);

    a_r5_reserved_open: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_o |-> !any_sw);

    a_r2_ref_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code_o != $past(ref_code_o)) |->
            (ref_code_o == $past(ref_code_o) + 5'd1 || ref_code_o == 5'd0));

    a_r6_switch_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        any_sw |-> code_valid_o);

    a_r11_change_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        adc_chg_o |-> code_valid_o);

endmodule

bind acc_id_ramp acc_id_ramp_chk u_chk (.*);

// File: tb/acc_id_ramp_bench.sv
module acc_id_ramp_bench;

    localparam int S    = 3;
    localparam int UNIT = 4;
    localparam int SMAX = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pres = 1'b0, vbus = 1'b0, raw = 1'b0, auto_sw = 1'b1, sw_en = 1'b1;
    logic [2:0] man_dp = 3'd0, man_dm = 3'd0;
    logic [3:0] wsel = 4'd0;
    logic cmp;
    int   tgt = 40;

    logic [4:0] ref_code, id_code, dev_class;
    logic code_valid, reserved, chg_det, attach, detach, adc_chg;
    logic dp_hs, dm_hs, dp_uart, dm_uart, jig, boot;

    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    assign cmp = (int'(ref_code) >= tgt);

    acc_id_ramp #(.SETTLE_CYC(S), .WAIT_UNIT_CYC(UNIT), .WAIT_SEL_MAX(SMAX)) u_acc_id_ramp (
        .clk(clk), .rst_n(rst_n), .acc_present_i(pres), .vbus_i(vbus), .cmp_i(cmp),
        .raw_mode_i(raw), .auto_sw_i(auto_sw), .sw_enable_i(sw_en),
        .man_dp_sel_i(man_dp), .man_dm_sel_i(man_dm), .wait_sel_i(wsel),
        .ref_code_o(ref_code), .id_code_o(id_code), .code_valid_o(code_valid),
        .dev_class_o(dev_class), .reserved_o(reserved), .chg_det_o(chg_det),
        .sw_dp_hs_o(dp_hs), .sw_dm_hs_o(dm_hs), .sw_dp_uart_o(dp_uart),
        .sw_dm_uart_o(dm_uart), .sw_jig_o(jig), .sw_boot_o(boot),
        .attach_o(attach), .detach_o(detach), .adc_chg_o(adc_chg));

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cls_of(int c);
        case (c)
            0: return 1;
            14: return 3;
            15, 16, 17, 18: return 4;
            19: return 5;
            20: return 6;
            21: return 7;
            22: return 8;
            23, 27: return 9;
            24: return 10;
            25: return 11;
            26: return 12;
            28: return 13;
            29: return 14;
            30: return 15;
            31: return 16;
            default: return 2;
        endcase
    endfunction

    // bit order: dp_hs dm_hs dp_uart dm_uart jig boot
    function automatic int auto_sw_of(int cl);
        int v = 0;
        if (cl == 1 || cl == 9 || cl == 10 || cl == 11) v |= 6'b110000;
        if (cl == 6 || cl == 8 || cl == 13 || cl == 14) v |= 6'b001100;
        if (cl == 10 || cl == 11 || cl == 13 || cl == 14) v |= 6'b000010;
        if (cl == 11 || cl == 14) v |= 6'b000001;
        return v;
    endfunction

    function automatic int man_sw_of(int dp, int dm);
        int v = 0;
        if (dp == 1) v |= 6'b100000;
        if (dm == 1) v |= 6'b010000;
        if (dp == 3) v |= 6'b001000;
        if (dm == 3) v |= 6'b000100;
        return v;
    endfunction

    function automatic int wait_len(int sel);
        int s = (sel > SMAX) ? SMAX : sel;
        return UNIT * (1 + 2 * s);
    endfunction

    // behavioural reference model; phase 0 idle, 1 first scan, 2 delay, 3 held, 4 rescan
    int m_ph = 0, m_ref = 0, m_cnt = 0, m_wt = 0, m_code = 31, m_valid = 0;
    int m_sw = 0, m_cls = 0, m_rsv = 0, m_chg = 0, m_att = 0, m_det = 0, m_adc = 0, m_pres = 0;

    always @(posedge clk) begin : model
        int a, d, c;
        if (!rst_n) begin
            m_ph = 0; m_ref = 0; m_cnt = 0; m_wt = 0; m_code = 31; m_valid = 0;
            m_sw = 0; m_cls = 0; m_rsv = 0; m_chg = 0; m_att = 0; m_det = 0; m_adc = 0; m_pres = 0;
        end else begin
            a = (pres && m_pres == 0) ? 1 : 0;
            d = (!pres && m_pres == 1) ? 1 : 0;
            m_pres = pres ? 1 : 0;
            m_att = a; m_det = d; m_adc = 0;
            if (d == 1 || !(m_ph == 3 || m_ph == 4)) begin
                m_sw = 0; m_cls = 0; m_rsv = 0; m_chg = 0;
            end else begin
                c = cls_of(m_code);
                m_cls = c;
                m_sw = !sw_en ? 0 : (auto_sw ? auto_sw_of(c) : man_sw_of(man_dp, man_dm));
                m_rsv = (c == 4) ? 1 : 0;
                m_chg = (c == 16 && vbus) ? 1 : 0;
            end
            if (d == 1) begin
                m_ph = 0; m_ref = 0; m_cnt = 0; m_code = 31; m_valid = 0;
            end else begin
                case (m_ph)
                    0: if (a == 1) begin m_ph = 1; m_ref = 0; m_cnt = 0; end
                    1, 4: begin
                        if (m_cnt == S - 1) begin
                            m_cnt = 0;
                            if (m_ref >= tgt || m_ref == 31) begin
                                if (m_ph == 4 && m_ref != m_code) m_adc = 1;
                                m_code = m_ref; m_valid = 1; m_wt = 0;
                                m_ph = (m_ph == 1) ? 2 : 3;
                            end else m_ref++;
                        end else m_cnt++;
                    end
                    2: if (m_wt == wait_len(int'(wsel)) - 1) m_ph = 3; else m_wt++;
                    3: if (raw) begin m_ph = 4; m_ref = 0; m_cnt = 0; end
                    default: m_ph = 0;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "ref_code", int'(ref_code), m_ref);
            chk("R2", "id_code", int'(id_code), m_code);
            chk("R2", "code_valid", int'(code_valid), m_valid);
            chk("R4", "switches", int'({dp_hs, dm_hs, dp_uart, dm_uart, jig, boot}), m_sw);
            chk("R12", "class", int'(dev_class), m_cls);
            chk("R5", "reserved", int'(reserved), m_rsv);
            chk("R5", "chg_det", int'(chg_det), m_chg);
            chk("R9", "attach", int'(attach), m_att);
            chk("R9", "detach", int'(detach), m_det);
            chk("R11", "adc_chg", int'(adc_chg), m_adc);
        end
    end

    function automatic int sw_all();
        return int'({dp_hs, dm_hs, dp_uart, dm_uart, jig, boot});
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic plug(int t);
        tgt = t; pres = 1'b1; cyc(S * 33 + wait_len(int'(wsel)) + 10);
    endtask

    task automatic unplug();
        pres = 1'b0; cyc(4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        int t;
        int pulses;
        cyc(5);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "ref", int'(ref_code), 0);
        chk("R1", "id", int'(id_code), 31);
        chk("R1", "valid", int'(code_valid), 0);
        chk("R1", "switches", sw_all(), 0);
        chk("R1", "class", int'(dev_class), 0);
        cyc(3);

        // R2 ramp timing for code 5
        tgt = 5; pres = 1'b1;
        while (!attach) @(negedge clk);
        t = 0;
        while (!code_valid) begin @(negedge clk); t++; end
        chk("R2", "latch delay", t, S * 6);
        chk("R2", "latched code", int'(id_code), 5);
        cyc(40);
        chk("R12", "unlisted class", int'(dev_class), 2);
        pres = 1'b0;
        @(negedge clk);
        chk("R9", "detach pulse", int'(detach), 1);
        chk("R9", "valid cleared", int'(code_valid), 0);
        @(negedge clk);
        chk("R9", "detach one cycle", int'(detach), 0);
        cyc(3);

        // R4 OTG
        plug(0);
        chk("R4", "otg switches", sw_all(), 6'b110000);
        chk("R12", "otg class", int'(dev_class), 1);
        // R10 raw off: comparator change ignored
        tgt = 9; cyc(150);
        chk("R10", "code held", int'(id_code), 0);
        chk("R10", "ref held", int'(ref_code), 0);
        // R9 detach opens at once
        pres = 1'b0; @(negedge clk);
        chk("R9", "detach opens", sw_all(), 0);
        cyc(3);

        // R6 wait, setting 2 and clamped setting 15
        wsel = 4'd2; tgt = 23; pres = 1'b1;
        while (!code_valid) @(negedge clk);
        t = 0;
        while (!dp_hs) begin @(negedge clk); t++; end
        chk("R6", "wait sel 2", t, wait_len(2) + 1);
        unplug();
        wsel = 4'd15; tgt = 27; pres = 1'b1;
        while (!code_valid) @(negedge clk);
        t = 0;
        while (!dp_hs) begin @(negedge clk); t++; end
        chk("R6", "wait clamped", t, UNIT * (1 + 2 * SMAX) + 1);
        unplug();
        wsel = 4'd0;

        // R4 UART and factory cables
        plug(22); chk("R4", "uart cable", sw_all(), 6'b001100); unplug();
        plug(20); chk("R4", "ppd", sw_all(), 6'b001100); unplug();
        plug(25); chk("R4", "factory usb boot", sw_all(), 6'b110011); unplug();
        plug(28); chk("R4", "factory uart", sw_all(), 6'b001110);
        chk("R12", "factory uart class", int'(dev_class), 13);
        unplug();

        // R5 reserved
        plug(16);
        chk("R5", "reserved flag", int'(reserved), 1);
        chk("R5", "reserved open", sw_all(), 0);
        unplug();

        // R3 saturation and R5 charger hand-off
        vbus = 1'b1;
        plug(40);
        chk("R3", "saturated code", int'(id_code), 31);
        chk("R5", "chg hand-off", int'(chg_det), 1);
        vbus = 1'b0; cyc(2);
        chk("R5", "no vbus no hand-off", int'(chg_det), 0);
        unplug();

        // R7 manual selection
        plug(22);
        auto_sw = 1'b0; man_dp = 3'b011; man_dm = 3'b001; cyc(2);
        chk("R7", "manual uart/hs", sw_all(), 6'b001000 | 6'b010000);
        man_dp = 3'b010; man_dm = 3'b111; cyc(2);
        chk("R7", "manual open codes", sw_all(), 0);
        man_dp = 3'b001; man_dm = 3'b011; cyc(2);
        chk("R7", "manual hs/uart", sw_all(), 6'b100100);
        // R8 force open
        sw_en = 1'b0; cyc(2);
        chk("R8", "forced open manual", sw_all(), 0);
        auto_sw = 1'b1; cyc(2);
        chk("R8", "forced open auto", sw_all(), 0);
        sw_en = 1'b1; cyc(2);
        chk("R8", "reopened auto", sw_all(), 6'b001100);

        // R11 raw mode rescan
        raw = 1'b1; tgt = 10; pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (adc_chg) pulses++;
        end
        chk("R11", "one change pulse", pulses, 1);
        chk("R11", "new code", int'(id_code), 10);
        raw = 1'b0; cyc(120);
        unplug();

        cyc(5);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule